// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block produces the serial clock for a flash command sequencer from the controller clock. A 20-bit timing word sets the length of one serial period in controller cycles and, within that period, the cycles at which the clock goes low, goes high, and at which read data should be captured. The low and high phases therefore need not be equal, so the duty cycle and the capture point can be tuned to the board.

The sequencer starts a transfer by raising the enable with a non-zero bit count. The generator then produces one falling edge per bit, with a one-cycle shift strobe on each, and a one-cycle sample strobe at the capture position. The clock rests high between transfers, as SPI mode 3 needs. After the last bit, or when enable drops early, the clock finishes its current low phase at the next rising position, the block goes idle and it pulses a done strobe. The timing word and the bit count are captured when the transfer starts.

Top module: `sclk_gen`

## Requirements
- R1: After reset, `sck` is 1 and `busy`, `shift_stb`, `sample_stb` and `done` are 0.
- R2: The timing word places the period length P in bits 3:0, the rising position in bits 11:8, the falling position in bits 15:12 and the capture position in bits 19:16. Consecutive falling edges of `sck` are P controller cycles apart.
- R3: The low phase of `sck` lasts (rise - fall) mod P cycles, so a falling position above the rising position wraps across the period boundary.
- R4: A period field of 0 or 1 acts as a period of 2.
- R5: A transfer of N bits gives exactly N falling edges of `sck`, and `shift_stb` is a one-cycle pulse in the cycle where `sck` first reads low, and at no other time.
- R6: `sample_stb` pulses once per bit, (capture - fall) cycles after the falling edge of that bit, when the capture position lies between the falling and rising positions.
- R7: When `en` is seen high while idle with a non-zero `nbits`, the first falling edge of `sck` is visible F+2 cycles after the cycle in which `en` was driven, F being the falling position. With `nbits` equal to 0, `en` starts nothing.
- R8: After the last bit, `sck` rises at the rising position, `busy` drops at the same edge and `done` is high for exactly one cycle with `sck` high.
- R9: If `en` drops during a transfer, no further falling edge occurs, the current low phase keeps its full length, and the transfer ends with `done` at the next rising position.
- R10: Changes to `timing` or `nbits` during a transfer have no effect on that transfer.
- R11: While idle, `sck` stays high and neither strobe pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request from the sequencer |
| timing | input | 20 | Period, rising, falling and capture positions |
| nbits | input | CW | Number of bits in the transfer |
| sck | output | 1 | Serial clock, idles high |
| shift_stb | output | 1 | One-cycle pulse at each falling edge |
| sample_stb | output | 1 | One-cycle pulse at the capture position |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the clock has come to rest |

## Verification
The hardest situation to reach is an early stop. It needs `en` to fall while `sck` is low, partway through a long transfer, so that the trailing low phase has to stretch to its full length rather than being cut. The bench starts a 100-bit transfer, watches the clock at each falling controller edge and drops `en` in the same cycle the second falling edge appears. It then checks the last low width, the edge count and the done strobe. A second scenario rewrites `timing` and `nbits` right after the first edge, to show that the captured values stay in force.

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [19:0]   timing,
  input  logic [CW-1:0] nbits,
  output logic          sck,
  output logic          shift_stb,
  output logic          sample_stb,
  output logic          busy,
  output logic          done
);

  localparam int FW = 4;

  logic [FW-1:0] per_q, rise_q, fall_q, capt_q, pos;
  logic [CW-1:0] rem;
  logic          run, stopping, sck_q, shift_q, capt_stb_q, done_q;

  wire [FW-1:0] per_in   = timing[3:0];
  wire [FW-1:0] per_eff  = (per_in < FW'(2)) ? FW'(2) : per_in;
  wire          stop_now = stopping | ~en;
  wire          fall_hit = run & ~stop_now & (pos == fall_q);
  wire          rise_hit = run & (pos == rise_q);
  wire          finish   = rise_hit & stop_now;
  wire          start    = ~run & en & (nbits != '0);
  wire          wrap     = (pos == per_q - FW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      stopping   <= 1'b0;
      pos        <= '0;
      rem        <= '0;
      per_q      <= FW'(2);
      rise_q     <= '0;
      fall_q     <= '0;
      capt_q     <= '0;
      sck_q      <= 1'b1;
      shift_q    <= 1'b0;
      capt_stb_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      shift_q    <= fall_hit;
      capt_stb_q <= run & (pos == capt_q);
      done_q     <= finish;
      if (start) begin
        run      <= 1'b1;
        stopping <= 1'b0;
        pos      <= '0;
        rem      <= nbits;
        per_q    <= per_eff;
        rise_q   <= timing[11:8];
        fall_q   <= timing[15:12];
        capt_q   <= timing[19:16];
      end else if (run) begin
        pos <= wrap ? '0 : pos + FW'(1);
        if (fall_hit) begin
          sck_q <= 1'b0;
          rem   <= rem - CW'(1);
          if (rem == CW'(1)) stopping <= 1'b1;
        end
        if (rise_hit) sck_q <= 1'b1;
        if (!en) stopping <= 1'b1;
        if (finish) run <= 1'b0;
      end
    end
  end

  assign sck        = sck_q;
  assign shift_stb  = shift_q;
  assign sample_stb = capt_stb_q;
  assign busy       = run;
  assign done       = done_q;

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic shift_stb,
  input logic sample_stb,
  input logic busy,
  input logic done
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  assert_shift_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> $fell(sck));

  assert_fall_has_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck) |-> shift_stb);

  assert_start_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sck);

  assert_done_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sck && !busy));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_shift_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> !shift_stb);

  assert_no_sample_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> !sample_stb);

endmodule

bind sclk_gen sclk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .shift_stb(shift_stb),
  .sample_stb(sample_stb), .busy(busy), .done(done)
);

// File: tb/sclk_gen_bench.sv
module sclk_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [19:0] timing = '0;
  logic [CW-1:0] nbits = '0;
  logic sck, shift_stb, sample_stb, busy, done;

  int tests = 0, fails = 0;

  sclk_gen #(.CW(CW)) u_sclk_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .timing(timing), .nbits(nbits),
    .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, falls = 0, shifts = 0, samples = 0, dones = 0, bad_shift = 0;
  int fall_cyc = 0, last_low = 0, last_per = 0, last_soff = 0, done_low = 0;
  logic prev_sck = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (prev_sck && !sck) begin
        if (falls > 0) last_per <= cyc - fall_cyc;
        fall_cyc <= cyc;
        falls <= falls + 1;
        if (!shift_stb) bad_shift <= bad_shift + 1;
      end else if (shift_stb) bad_shift <= bad_shift + 1;
      if (!prev_sck && sck) last_low <= cyc - fall_cyc;
      if (shift_stb) shifts <= shifts + 1;
      if (sample_stb) begin
        samples <= samples + 1;
        last_soff <= cyc - fall_cyc;
      end
      if (done) begin
        dones <= dones + 1;
        if (!sck || busy) done_low <= done_low + 1;
      end
    end
    prev_sck <= sck;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] tw(int p, int r, int f, int s);
    return {4'(s), 4'(f), 4'(r), 4'b0, 4'(p)};
  endfunction

  task automatic wait_done();
    int d0 = dones;
    for (int k = 0; k < 5000 && dones == d0; k++) step();
    en = 1'b0;
  endtask

  task automatic t_reset();
    chk(sck == 1'b1, "R1 sck", int'(sck), 1);
    chk(busy == 1'b0 && shift_stb == 1'b0, "R1 busy/shift", int'(busy), 0);
    chk(sample_stb == 1'b0 && done == 1'b0, "R1 sample/done", int'(done), 0);
  endtask

  task automatic t_xfer(string tag, int p, int r, int f, int s, int n);
    int pe = (p < 2) ? 2 : p;
    int f0 = falls, s0 = samples, d0 = dones, sh0 = shifts, b0 = bad_shift;
    int lat = 0;
    timing = tw(p, r, f, s);
    nbits = CW'(n);
    en = 1'b1;
    do begin step(); lat++; end while (sck != 1'b0 && lat < 100);
    chk(lat == f + 2, {tag, " R7 first-fall latency"}, lat, f + 2);
    wait_done();
    step();
    chk(falls - f0 == n, {tag, " R5 fall count"}, falls - f0, n);
    chk(shifts - sh0 == n && bad_shift == b0, {tag, " R5 shift strobes"}, shifts - sh0, n);
    chk(last_low == ((r - f + pe) % pe), {tag, " R3 low width"}, last_low, (r - f + pe) % pe);
    if (n > 1) chk(last_per == pe, {tag, " R2/R4 period"}, last_per, pe);
    chk(samples - s0 == n, {tag, " R6 sample count"}, samples - s0, n);
    chk(last_soff == s - f, {tag, " R6 sample offset"}, last_soff, s - f);
    chk(dones - d0 == 1 && done_low == 0, {tag, " R8 done pulse"}, dones - d0, 1);
    chk(!busy && sck, {tag, " R8 idle after"}, int'(sck), 1);
  endtask

  task automatic t_zero_bits();
    int f0 = falls;
    timing = tw(4, 2, 0, 2);
    nbits = '0;
    en = 1'b1;
    repeat (20) step();
    chk(falls == f0 && !busy && sck, "R7 zero count starts nothing", falls - f0, 0);
    en = 1'b0;
    step();
  endtask

  task automatic t_abort();
    int f0 = falls, d0 = dones;
    timing = tw(8, 4, 0, 2);
    nbits = CW'(100);
    en = 1'b1;
    for (int k = 0; k < 200 && falls - f0 < 2; k++) step();
    en = 1'b0;
    for (int k = 0; k < 200 && dones == d0; k++) step();
    repeat (20) step();
    chk(falls - f0 == 2, "R9 no edge after enable drop", falls - f0, 2);
    chk(last_low == 4, "R9 full final low phase", last_low, 4);
    chk(dones - d0 == 1 && sck && !busy, "R9 done after abort", dones - d0, 1);
  endtask

  task automatic t_latch();
    int f0 = falls;
    timing = tw(4, 2, 0, 2);
    nbits = CW'(4);
    en = 1'b1;
    for (int k = 0; k < 100 && falls == f0; k++) step();
    timing = tw(12, 9, 3, 5);
    nbits = CW'(1);
    wait_done();
    step();
    chk(falls - f0 == 4, "R10 bit count held", falls - f0, 4);
    chk(last_per == 4 && last_low == 2, "R10 timing held", last_per, 4);
  endtask

  task automatic t_idle();
    int sh0 = shifts, s0 = samples;
    timing = tw(4, 2, 0, 1);
    nbits = CW'(5);
    repeat (30) step();
    chk(shifts == sh0 && samples == s0 && sck, "R11 idle quiet", shifts - sh0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_xfer("div2", 4, 2, 0, 2, 3);
    t_xfer("div6", 12, 6, 0, 5, 2);
    t_xfer("offset", 6, 4, 1, 3, 4);
    t_xfer("wrap R3", 8, 1, 5, 7, 2);
    t_xfer("per0 R4", 0, 1, 0, 1, 3);
    t_xfer("per1 R4", 1, 1, 0, 1, 2);
    t_zero_bits();
    t_abort();
    t_latch();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule